// File: doc/BRIEF.md
# Hierarchical State-Enable Register Bank

This block holds the state-enable control registers of a processor at three privilege tiers: machine, hypervisor and supervisor. Each tier has four 64-bit registers. Software reaches them through a 12-bit control-register address. Each bit enables one piece of architectural state for the tier below, so that the lower tier cannot use that state as a hidden channel. The block does not gate the state. It only stores the enables and controls who may change them.

Writes are filtered per bit. The machine tier has a fixed writable mask. The hypervisor tier may change a bit only while the machine register at the same index holds that bit set. The supervisor tier is gated by the hypervisor register when the hart runs virtualized, and by the machine register otherwise. On a 32-bit datapath, the upper words of the machine and hypervisor registers have addresses of their own. Any access to a mapped address returns an illegal indication when the feature is off or the privilege is too low, and such an access changes nothing.

Top module: `stateen_csr`

## Requirements
- R1: Every register of every tier reads zero after reset.
- R2: A register is selected only while `acc_en` is high. Machine index i sits at 0x30C+i, hypervisor at 0x60C+i and supervisor at 0x10C+i. With a 32-bit datapath, machine and hypervisor upper words sit at 0x31C+i and 0x61C+i. Any other address gives `acc_hit`=0, `acc_illegal`=0 and `acc_rdata`=0.
- R3: A legal write stores (old & ~mask) | (data & mask). The machine mask is bits 63, 62, 60, 59, 58, 1 and 0 for index 0, and bit 63 alone for indices 1 to 3.
- R4: The hypervisor mask is its own fixed mask (same default as machine) ANDed with the current machine register of the same index. Clearing a machine bit later leaves the hypervisor bit as it was.
- R5: The supervisor mask is its own fixed mask (bits 1 and 0 for index 0, none for the others) ANDed with the same-index hypervisor register when `virt`=1, or with the same-index machine register when `virt`=0.
- R6: With a 32-bit datapath, a write to an upper-word address puts the data in bits 63:32, keeps bits 31:0 and then applies the mask. A read there returns bits 63:32, and a read of the base address returns bits 31:0.
- R7: When `feat_en`=0, every selected access raises `acc_illegal`, reads zero and writes nothing.
- R8: Privilege is encoded as 3 for machine, 1 for supervisor and 0 for user. Machine addresses need machine privilege. Hypervisor addresses need machine privilege, or supervisor privilege with `virt`=0. Supervisor addresses need machine or supervisor privilege. Any other selected access raises `acc_illegal`, reads zero and changes no register.
- R9: Read data is combinational from the selected register in the same cycle, and a write takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| feat_en | input | 1 | Feature enable |
| priv | input | 2 | Current privilege (3 machine, 1 supervisor, 0 user) |
| virt | input | 1 | Virtualization mode active |
| acc_en | input | 1 | Access request |
| acc_we | input | 1 | Access is a write |
| acc_addr | input | 12 | Control-register address |
| acc_wdata | input | DW | Write data |
| acc_rdata | output | DW | Read data |
| acc_hit | output | 1 | Address maps to this bank |
| acc_illegal | output | 1 | Access refused |

## Verification
The bench targets the gating chain. A hypervisor write of all ones under a clear machine register must store nothing. A design that used a fixed mask would let the bits through. Clearing a machine bit must leave an already-set hypervisor bit in place. A design that masked the stored value instead of the write would lose it. The supervisor register is written in both virtualization modes against parents that differ in bit 1, which exposes a swapped parent choice. Upper-word writes are read back at both halves, so a design that clobbered the low word fails. Refused writes are followed by legal reads of the same register, and these catch any write that slips through on a privilege or enable fault.

// File: rtl/stateen_csr.sv
module stateen_csr #(
  parameter int          DW      = 32,
  parameter logic [63:0] M_MASK0 = 64'hDC00_0000_0000_0003,
  parameter logic [63:0] M_MASKN = 64'h8000_0000_0000_0000,
  parameter logic [63:0] H_MASK0 = 64'hDC00_0000_0000_0003,
  parameter logic [63:0] H_MASKN = 64'h8000_0000_0000_0000,
  parameter logic [63:0] S_MASK0 = 64'h0000_0000_0000_0003,
  parameter logic [63:0] S_MASKN = 64'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          feat_en,
  input  logic [1:0]    priv,
  input  logic          virt,
  input  logic          acc_en,
  input  logic          acc_we,
  input  logic [11:0]   acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  output logic          acc_hit,
  output logic          acc_illegal
);
  localparam int  NREG   = 4;
  localparam bit  SPLIT  = (DW == 32);

  logic [NREG-1:0][63:0] mreg, hreg, sreg;

  wire [1:0] idx  = acc_addr[1:0];
  wire       slot = acc_en && (acc_addr[3:2] == 2'b11);
  wire       m_lo = slot && (acc_addr[11:4] == 8'h30);
  wire       m_hi = slot && SPLIT && (acc_addr[11:4] == 8'h31);
  wire       h_lo = slot && (acc_addr[11:4] == 8'h60);
  wire       h_hi = slot && SPLIT && (acc_addr[11:4] == 8'h61);
  wire       s_lo = slot && (acc_addr[11:4] == 8'h10);
  wire       m_any = m_lo | m_hi;
  wire       h_any = h_lo | h_hi;
  wire       hi    = m_hi | h_hi;

  wire is_m = (priv == 2'b11);
  wire is_s = (priv == 2'b01);

  logic priv_ok;
  always_comb begin
    if (m_any)      priv_ok = is_m;
    else if (h_any) priv_ok = is_m | (is_s & ~virt);
    else            priv_ok = is_m | is_s;
  end

  assign acc_hit     = m_any | h_any | s_lo;
  assign acc_illegal = acc_hit & (~feat_en | ~priv_ok);
  wire   legal       = acc_hit & ~acc_illegal;
  wire   wr          = legal & acc_we;

  logic [63:0] cur, mask, comp, nxt;

  always_comb begin
    if (m_any) begin
      cur  = mreg[idx];
      mask = (idx == 2'd0) ? M_MASK0 : M_MASKN;
    end else if (h_any) begin
      cur  = hreg[idx];
      mask = ((idx == 2'd0) ? H_MASK0 : H_MASKN) & mreg[idx];
    end else begin
      cur  = sreg[idx];
      mask = ((idx == 2'd0) ? S_MASK0 : S_MASKN) & (virt ? hreg[idx] : mreg[idx]);
    end
  end

  generate
    if (SPLIT) begin : g_narrow
      assign comp      = hi ? {acc_wdata, cur[31:0]} : {cur[63:32], acc_wdata};
      assign acc_rdata = !legal ? '0 : (hi ? cur[63:32] : cur[31:0]);
    end else begin : g_wide
      assign comp      = acc_wdata;
      assign acc_rdata = legal ? cur : '0;
    end
  endgenerate

  assign nxt = (cur & ~mask) | (comp & mask);

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mreg[i] <= '0;
          hreg[i] <= '0;
          sreg[i] <= '0;
        end else if (wr && (idx == i)) begin
          if (m_any)      mreg[i] <= nxt;
          else if (h_any) hreg[i] <= nxt;
          else            sreg[i] <= nxt;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/stateen_csr_chk.sv
module stateen_csr_chk #(
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              feat_en,
  input logic [1:0]        priv,
  input logic              virt,
  input logic              acc_en,
  input logic              acc_we,
  input logic              acc_hit,
  input logic              acc_illegal,
  input logic [DW-1:0]     acc_rdata,
  input logic [3:0][63:0]  mreg,
  input logic [3:0][63:0]  hreg,
  input logic [3:0][63:0]  sreg
);
  AST_OFF_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit && !feat_en |-> acc_illegal); // R7
  AST_USER_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit && priv == 2'b00 |-> acc_illegal); // R8
  AST_ILL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    acc_illegal && acc_we |=> mreg == $past(mreg) && hreg == $past(hreg) && sreg == $past(sreg)); // R8
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && !acc_hit |-> acc_rdata == '0 && !acc_illegal); // R2
  AST_HYP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> ((hreg ^ $past(hreg)) & ~$past(mreg)) == '0); // R4
  AST_SUP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> ((sreg ^ $past(sreg)) & ~($past(virt) ? $past(hreg) : $past(mreg))) == '0); // R5
endmodule

bind stateen_csr stateen_csr_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_stateen_csr.sv
module sim_stateen_csr;
  logic        clk = 0, rst_n = 0;
  logic        feat_en = 1, virt = 0, acc_en = 0, acc_we = 0;
  logic [1:0]  priv = 2'd3;
  logic [11:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        acc_hit, acc_illegal;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stateen_csr #(.DW(32)) u0 (.*);

  // {we, priv, virt, feat, addr, wdata, exp_rdata, exp_hit, exp_ill, req}
  localparam int NV = 44;
  localparam logic [86:0] VEC [NV] = '{
    {1'b0,2'd3,1'b0,1'b1,12'h30C,32'h0,32'h0,1'b1,1'b0,4'd1},               // R1
    {1'b0,2'd3,1'b0,1'b1,12'h61F,32'h0,32'h0,1'b1,1'b0,4'd1},               // R1
    {1'b0,2'd3,1'b0,1'b1,12'h10F,32'h0,32'h0,1'b1,1'b0,4'd1},               // R1
    {1'b1,2'd3,1'b0,1'b1,12'h30C,32'hFFFFFFFF,32'h0,1'b1,1'b0,4'd3},        // R3
    {1'b0,2'd3,1'b0,1'b1,12'h30C,32'h0,32'h3,1'b1,1'b0,4'd3},               // R3
    {1'b1,2'd3,1'b0,1'b1,12'h31C,32'hFFFFFFFF,32'h0,1'b1,1'b0,4'd6},        // R6
    {1'b0,2'd3,1'b0,1'b1,12'h31C,32'h0,32'hDC000000,1'b1,1'b0,4'd6},        // R6
    {1'b0,2'd3,1'b0,1'b1,12'h30C,32'h0,32'h3,1'b1,1'b0,4'd6},               // R6
    {1'b1,2'd3,1'b0,1'b1,12'h30D,32'hFFFFFFFF,32'h0,1'b1,1'b0,4'd3},        // R3
    {1'b0,2'd3,1'b0,1'b1,12'h30D,32'h0,32'h0,1'b1,1'b0,4'd3},               // R3
    {1'b1,2'd3,1'b0,1'b1,12'h31D,32'hFFFFFFFF,32'h0,1'b1,1'b0,4'd3},        // R3
    {1'b0,2'd3,1'b0,1'b1,12'h31D,32'h0,32'h80000000,1'b1,1'b0,4'd3},        // R3
    {1'b1,2'd1,1'b0,1'b1,12'h60C,32'h1,32'h0,1'b1,1'b0,4'd4},               // R4
    {1'b0,2'd1,1'b0,1'b1,12'h60C,32'h0,32'h1,1'b1,1'b0,4'd4},               // R4
    {1'b1,2'd1,1'b0,1'b1,12'h61C,32'hFFFFFFFF,32'h0,1'b1,1'b0,4'd4},        // R4
    {1'b0,2'd1,1'b0,1'b1,12'h61C,32'h0,32'hDC000000,1'b1,1'b0,4'd4},        // R4
    {1'b1,2'd1,1'b0,1'b1,12'h61D,32'hFFFFFFFF,32'h0,1'b1,1'b0,4'd4},        // R4
    {1'b0,2'd1,1'b0,1'b1,12'h61D,32'h0,32'h80000000,1'b1,1'b0,4'd4},        // R4
    {1'b1,2'd1,1'b0,1'b1,12'h61E,32'hFFFFFFFF,32'h0,1'b1,1'b0,4'd4},        // R4
    {1'b0,2'd1,1'b0,1'b1,12'h61E,32'h0,32'h0,1'b1,1'b0,4'd4},               // R4
    {1'b1,2'd1,1'b0,1'b1,12'h10C,32'hFFFFFFFF,32'h0,1'b1,1'b0,4'd5},        // R5
    {1'b0,2'd1,1'b0,1'b1,12'h10C,32'h0,32'h3,1'b1,1'b0,4'd5},               // R5
    {1'b1,2'd1,1'b1,1'b1,12'h10C,32'h0,32'h0,1'b1,1'b0,4'd5},               // R5
    {1'b0,2'd1,1'b1,1'b1,12'h10C,32'h0,32'h2,1'b1,1'b0,4'd5},               // R5
    {1'b1,2'd1,1'b0,1'b1,12'h10C,32'h0,32'h0,1'b1,1'b0,4'd5},               // R5
    {1'b1,2'd1,1'b1,1'b1,12'h10C,32'hFFFFFFFF,32'h0,1'b1,1'b0,4'd5},        // R5
    {1'b0,2'd1,1'b1,1'b1,12'h10C,32'h0,32'h1,1'b1,1'b0,4'd5},               // R5
    {1'b0,2'd1,1'b1,1'b1,12'h60C,32'h0,32'h0,1'b1,1'b1,4'd8},               // R8
    {1'b0,2'd0,1'b0,1'b1,12'h10C,32'h0,32'h0,1'b1,1'b1,4'd8},               // R8
    {1'b0,2'd1,1'b0,1'b1,12'h30C,32'h0,32'h0,1'b1,1'b1,4'd8},               // R8
    {1'b1,2'd1,1'b0,1'b1,12'h30C,32'h0,32'h0,1'b1,1'b1,4'd8},               // R8
    {1'b0,2'd3,1'b0,1'b1,12'h30C,32'h0,32'h3,1'b1,1'b0,4'd8},               // R8
    {1'b0,2'd3,1'b0,1'b0,12'h30C,32'h0,32'h0,1'b1,1'b1,4'd7},               // R7
    {1'b1,2'd3,1'b0,1'b0,12'h30C,32'h0,32'h0,1'b1,1'b1,4'd7},               // R7
    {1'b0,2'd3,1'b0,1'b1,12'h30C,32'h0,32'h3,1'b1,1'b0,4'd7},               // R7
    {1'b0,2'd3,1'b0,1'b1,12'h30B,32'h0,32'h0,1'b0,1'b0,4'd2},               // R2
    {1'b0,2'd3,1'b0,1'b1,12'h11C,32'h0,32'h0,1'b0,1'b0,4'd2},               // R2
    {1'b1,2'd3,1'b0,1'b1,12'h31D,32'h0,32'h0,1'b1,1'b0,4'd4},               // R4
    {1'b0,2'd3,1'b0,1'b1,12'h31D,32'h0,32'h0,1'b1,1'b0,4'd4},               // R4
    {1'b0,2'd3,1'b0,1'b1,12'h61D,32'h0,32'h80000000,1'b1,1'b0,4'd4},        // R4
    {1'b1,2'd3,1'b0,1'b1,12'h61D,32'h0,32'h0,1'b1,1'b0,4'd4},               // R4
    {1'b0,2'd3,1'b0,1'b1,12'h61D,32'h0,32'h80000000,1'b1,1'b0,4'd4},        // R4
    {1'b1,2'd3,1'b0,1'b1,12'h10D,32'hFFFFFFFF,32'h0,1'b1,1'b0,4'd5},        // R5
    {1'b0,2'd3,1'b0,1'b1,12'h10D,32'h0,32'h0,1'b1,1'b0,4'd5}                // R5
  };

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [86:0] v);
    @(negedge clk);
    acc_we = v[86]; priv = v[85:84]; virt = v[83]; feat_en = v[82];
    acc_addr = v[81:70]; acc_wdata = v[69:38]; acc_en = 1'b1;
    #1;
    check(acc_hit == v[5], int'(v[3:0]), "hit", {31'b0, acc_hit}, {31'b0, v[5]});
    check(acc_illegal == v[4], int'(v[3:0]), "illegal", {31'b0, acc_illegal}, {31'b0, v[4]});
    if (!v[86])  // R9: combinational read in the same cycle
      check(acc_rdata == v[37:6], int'(v[3:0]), "rdata", acc_rdata, v[37:6]);
    @(posedge clk);
    #1;
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    for (int i = 0; i < NV; i++) access(VEC[i]);

    // R2: no selection while acc_en is low
    @(negedge clk);
    acc_en = 0; acc_addr = 12'h30C; priv = 2'd3; feat_en = 1;
    #1;
    check(acc_hit == 1'b0, 2, "hit without enable", {31'b0, acc_hit}, 32'h0);

    // R1: mid-run reset clears stored values
    @(negedge clk) rst_n = 0;
    @(negedge clk) rst_n = 1;
    access({1'b0,2'd3,1'b0,1'b1,12'h31C,32'h0,32'h0,1'b1,1'b0,4'd1});
    access({1'b0,2'd3,1'b0,1'b1,12'h61D,32'h0,32'h0,1'b1,1'b0,4'd1});
    access({1'b0,2'd3,1'b0,1'b1,12'h10C,32'h0,32'h0,1'b1,1'b0,4'd1});
    finish_run();
  end
endmodule